// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block recovers characters from an asynchronous serial line. A receive clock enable (`rx_tick`) paces the sampling. The divide code on `div_sel` sets how many ticks make up one bit: 1, 16 or 64. In the divided modes a falling edge on the line arms a start-bit check at the half-bit point. Each later bit is then sampled at its centre. In the undivided mode every tick is one bit sample. The shared word-select code sets the frame: 7 or 8 data bits, least significant first, then an optional even or odd parity bit, then the stop bit(s).

A finished character moves into a holding register, and the framing and parity verdicts move with it. The host takes the character by pulsing `data_rd`. If a second character completes while the first is still unread, the second is dropped. The overrun flag then appears once the held character has been read, and a further read clears it. The `div_sel` code 3 acts as a master reset of the receive path.

Two signals qualify the held state. The carrier-lost input masks the receive-full indication. A receive interrupt request is raised when the receive interrupt enable is set and one of these is present: a full register, a visible overrun, or a fresh loss of carrier.

Top module: `serial_rx_core`

## Requirements
- R1: Word-select codes decode as follows (code: data bits, parity): 0: 7 even; 1: 7 odd; 2: 7 even; 3: 7 odd; 4: 8 none; 5: 8 none; 6: 8 even; 7: 8 odd. Data bits arrive least significant first, and `rx_data` bit i holds the i-th data bit received.
- R2: When the word-select code is below 4 (7 data bits), `rx_data[7]` reads 0 while a character is held.
- R3: `frame_err` is set with a transferred character whose first stop bit was sampled low. It is cleared with a character whose first stop bit was high.
- R4: `parity_err` is set when the ones count of the data bits and the parity bit is odd for even parity, or even for odd parity. With no parity selected (codes 4 and 5) it is 0.
- R5: `frame_err` and `parity_err` change only when a character is transferred into the holding register. They do not change while the held character stays unread.
- R6: A character that completes while `rx_full` is set is discarded, and `overrun` stays 0. The first `data_rd` after that keeps `rx_full` set and raises `overrun`. The next `data_rd` clears both.
- R7: With no overrun pending, a `data_rd` clears `rx_full`. `div_sel` = 3 clears `rx_full`, `overrun`, `frame_err`, `parity_err` and any frame in progress.
- R8: While `carrier_lost` is 1, `rx_full` reads 0. The held character is kept, and `rx_full` returns when `carrier_lost` falls.
- R9: `rx_irq` is 1 exactly when `rx_irq_en` is 1 and one of these holds: `rx_full` is 1, `overrun` is 1, or `carrier_lost` has risen since the last `data_rd` or master reset.
- R10: With `div_sel` = 1 (÷16) or 2 (÷64), a low pulse on `rxd` that has ended by the half-bit point does not start a frame.
- R11: With `div_sel` = 0 (÷1), the tick that sees `rxd` low in idle is the start bit, and each following tick samples one bit.
- R12: Frame timing continues through an overrun. A character sent after the overrun has been cleared is received intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_tick | input | 1 | Receive clock enable, one pulse per tick |
| rxd | input | 1 | Serial receive line, idle high |
| div_sel | input | 2 | 0: ÷1, 1: ÷16, 2: ÷64, 3: master reset |
| word_sel | input | 3 | Frame format code (see R1) |
| rx_irq_en | input | 1 | Receive interrupt enable |
| carrier_lost | input | 1 | 1 while no carrier is present |
| data_rd | input | 1 | Host read of the data register, one-cycle pulse |
| rx_data | output | 8 | Held character |
| rx_full | output | 1 | Holding register full |
| frame_err | output | 1 | Framing error of the held character |
| parity_err | output | 1 | Parity error of the held character |
| overrun | output | 1 | Overrun visible |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The hardest state to reach from the ports is an overrun that is pending but not yet visible. Getting there takes two whole frames sent back to back with no read in between, and the first of them needs a bad parity bit so that R5 can be seen. The bench then steps through three points in turn: before the first read, after the first read and after the second read. At each point it checks that the flags still belong to the first character, and it sends a further frame to show that frame timing survived. The start-bit check is reached by pulling the line low for fewer ticks than half a bit in ÷16 mode, and then sending a valid frame.

// File: rtl/rx_pkg.sv
package rx_pkg;
  localparam int unsigned CHAR_W = 8;

  typedef enum logic [1:0] {SMP_IDLE, SMP_VERIFY, SMP_RUN} smp_state_e;

  typedef struct packed {
    logic wide;     // 8 data bits
    logic has_par;  // parity bit present
    logic odd;      // odd parity selected
  } frame_fmt_t;

  function automatic frame_fmt_t decode_fmt(input logic [2:0] ws);
    frame_fmt_t f;
    f.wide    = ws[2];
    f.has_par = ~ws[2] | ws[1];
    f.odd     = ws[0];
    return f;
  endfunction
endpackage

// File: rtl/rx_sampler.sv
module rx_sampler #(
  parameter int unsigned DIV_LO = 16,
  parameter int unsigned DIV_HI = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mreset,
  input  logic       tick,
  input  logic       rxd,
  input  logic [1:0] div_sel,
  input  logic       last_bit,
  output logic       start_stb,
  output logic       bit_stb
);
  import rx_pkg::*;
  localparam int unsigned CW = $clog2(DIV_HI);

  smp_state_e st_q, st_d;
  logic [CW:0] cnt_q, cnt_d;
  logic [CW:0] period, half;
  logic        div1;

  assign div1   = (div_sel == 2'd0);
  assign period = (div_sel == 2'd1) ? (CW+1)'(DIV_LO) : (CW+1)'(DIV_HI);
  assign half   = period >> 1;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    start_stb = 1'b0;
    bit_stb   = 1'b0;
    if (tick) begin
      unique case (st_q)
        SMP_IDLE: begin
          if (!rxd) begin
            cnt_d = '0;
            if (div1) begin
              start_stb = 1'b1;
              st_d      = SMP_RUN;
            end else begin
              st_d = SMP_VERIFY;
            end
          end
        end
        SMP_VERIFY: begin
          if (cnt_q == half - 1'b1) begin
            cnt_d = '0;
            if (!rxd) begin
              start_stb = 1'b1;
              st_d      = SMP_RUN;
            end else begin
              st_d = SMP_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          if (div1 || cnt_q == period - 1'b1) begin
            bit_stb = 1'b1;
            cnt_d   = '0;
            if (last_bit) st_d = SMP_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      endcase
    end
    if (mreset) begin
      st_d  = SMP_IDLE;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SMP_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mreset,
  input  logic                       start_stb,
  input  logic                       bit_stb,
  input  logic                       bit_val,
  input  logic [2:0]                 word_sel,
  output logic                       last_bit,
  output logic                       done,
  output logic [rx_pkg::CHAR_W-1:0]  char_out,
  output logic                       fe_out,
  output logic                       pe_out
);
  import rx_pkg::*;

  frame_fmt_t        fmt;
  logic [3:0]        pos_q, pos_d, stop_pos, data_end;
  logic [CHAR_W-1:0] sh_q, sh_d;
  logic              pacc_q, pacc_d;

  assign fmt      = decode_fmt(word_sel);
  assign data_end = 4'd7 + {3'b0, fmt.wide};
  assign stop_pos = data_end + {3'b0, fmt.has_par};
  assign last_bit = (pos_q == stop_pos);

  always_comb begin
    pos_d  = pos_q;
    sh_d   = sh_q;
    pacc_d = pacc_q;
    if (start_stb) begin
      pos_d  = '0;
      pacc_d = 1'b0;
    end else if (bit_stb && !last_bit) begin
      if (pos_q < data_end) sh_d = {bit_val, sh_q[CHAR_W-1:1]};
      pacc_d = pacc_q ^ bit_val;
      pos_d  = pos_q + 1'b1;
    end
    if (mreset) pos_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      sh_q   <= '0;
      pacc_q <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      sh_q   <= sh_d;
      pacc_q <= pacc_d;
    end
  end

  assign done     = bit_stb & last_bit & ~mreset;
  assign char_out = fmt.wide ? sh_q : {1'b0, sh_q[CHAR_W-1:1]};
  assign fe_out   = ~bit_val;
  assign pe_out   = fmt.has_par & (pacc_q ^ fmt.odd);
endmodule

// File: rtl/rx_hold.sv
module rx_hold (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mreset,
  input  logic                       done,
  input  logic [rx_pkg::CHAR_W-1:0]  char_in,
  input  logic                       fe_in,
  input  logic                       pe_in,
  input  logic                       data_rd,
  input  logic                       carrier_lost,
  input  logic                       irq_en,
  output logic [rx_pkg::CHAR_W-1:0]  rdr,
  output logic                       full_vis,
  output logic                       fe,
  output logic                       pe,
  output logic                       ovr_vis,
  output logic                       irq
);
  import rx_pkg::*;

  logic [CHAR_W-1:0] rdr_d;
  logic full_q, full_d, fe_d, pe_d, pend_q, pend_d, ovr_d;
  logic car_q, evt_q, evt_d;

  always_comb begin
    rdr_d  = rdr;
    full_d = full_q;
    fe_d   = fe;
    pe_d   = pe;
    pend_d = pend_q;
    ovr_d  = ovr_vis;
    evt_d  = evt_q;
    if (data_rd) begin
      evt_d = 1'b0;
      if (pend_q && !ovr_vis) begin
        ovr_d  = 1'b1;
        pend_d = 1'b0;
      end else begin
        full_d = 1'b0;
        ovr_d  = 1'b0;
      end
    end
    if (done) begin
      if (!full_d) begin
        rdr_d  = char_in;
        fe_d   = fe_in;
        pe_d   = pe_in;
        full_d = 1'b1;
      end else if (!ovr_d) begin
        pend_d = 1'b1;
      end
    end
    if (carrier_lost && !car_q) evt_d = 1'b1;
    if (mreset) begin
      full_d = 1'b0;
      fe_d   = 1'b0;
      pe_d   = 1'b0;
      pend_d = 1'b0;
      ovr_d  = 1'b0;
      evt_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdr     <= '0;
      full_q  <= 1'b0;
      fe      <= 1'b0;
      pe      <= 1'b0;
      pend_q  <= 1'b0;
      ovr_vis <= 1'b0;
      evt_q   <= 1'b0;
      car_q   <= 1'b0;
    end else begin
      rdr     <= rdr_d;
      full_q  <= full_d;
      fe      <= fe_d;
      pe      <= pe_d;
      pend_q  <= pend_d;
      ovr_vis <= ovr_d;
      evt_q   <= evt_d;
      car_q   <= carrier_lost;
    end
  end

  assign full_vis = full_q & ~carrier_lost;
  assign irq      = irq_en & (full_vis | ovr_vis | evt_q);
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
  parameter int unsigned DIV_LO = 16,
  parameter int unsigned DIV_HI = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_tick,
  input  logic       rxd,
  input  logic [1:0] div_sel,
  input  logic [2:0] word_sel,
  input  logic       rx_irq_en,
  input  logic       carrier_lost,
  input  logic       data_rd,
  output logic [7:0] rx_data,
  output logic       rx_full,
  output logic       frame_err,
  output logic       parity_err,
  output logic       overrun,
  output logic       rx_irq
);
  import rx_pkg::*;

  logic mreset, start_stb, bit_stb, last_bit, done, fe_w, pe_w;
  logic [CHAR_W-1:0] char_w;

  assign mreset = &div_sel;

  rx_sampler #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_smp (
    .clk(clk), .rst_n(rst_n), .mreset(mreset), .tick(rx_tick), .rxd(rxd),
    .div_sel(div_sel), .last_bit(last_bit), .start_stb(start_stb), .bit_stb(bit_stb)
  );

  rx_shifter u_shf (
    .clk(clk), .rst_n(rst_n), .mreset(mreset), .start_stb(start_stb),
    .bit_stb(bit_stb), .bit_val(rxd), .word_sel(word_sel), .last_bit(last_bit),
    .done(done), .char_out(char_w), .fe_out(fe_w), .pe_out(pe_w)
  );

  rx_hold u_hold (
    .clk(clk), .rst_n(rst_n), .mreset(mreset), .done(done), .char_in(char_w),
    .fe_in(fe_w), .pe_in(pe_w), .data_rd(data_rd), .carrier_lost(carrier_lost),
    .irq_en(rx_irq_en), .rdr(rx_data), .full_vis(rx_full), .fe(frame_err),
    .pe(parity_err), .ovr_vis(overrun), .irq(rx_irq)
  );
endmodule

// File: rtl/serial_rx_core_chk.sv
module serial_rx_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] div_sel,
  input logic [2:0] word_sel,
  input logic       rx_irq_en,
  input logic       carrier_lost,
  input logic       data_rd,
  input logic [7:0] rx_data,
  input logic       rx_full,
  input logic       frame_err,
  input logic       parity_err,
  input logic       overrun,
  input logic       rx_irq
);
  assert_seven_bit_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !word_sel[2]) |-> !rx_data[7]);

  assert_flags_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && $past(rx_full) && !$past(data_rd)) |-> ($stable(frame_err) && $stable(parity_err)));

  assert_overrun_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(data_rd));

  assert_mreset_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (&div_sel) |=> (!rx_full && !overrun && !frame_err && !parity_err));

  assert_carrier_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    carrier_lost |-> !rx_full);

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_irq_en);

  assert_irq_on_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq_en && (rx_full || overrun)) |-> rx_irq);
endmodule

bind serial_rx_core serial_rx_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .word_sel(word_sel),
  .rx_irq_en(rx_irq_en), .carrier_lost(carrier_lost), .data_rd(data_rd),
  .rx_data(rx_data), .rx_full(rx_full), .frame_err(frame_err),
  .parity_err(parity_err), .overrun(overrun), .rx_irq(rx_irq)
);

// File: tb/tb_serial_rx_core.sv
module tb_serial_rx_core;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, rx_tick, rxd, rx_irq_en, carrier_lost, data_rd;
  logic [1:0] div_sel;
  logic [2:0] word_sel;
  logic [7:0] rx_data;
  logic rx_full, frame_err, parity_err, overrun, rx_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_rx_core dut (
    .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .rxd(rxd), .div_sel(div_sel),
    .word_sel(word_sel), .rx_irq_en(rx_irq_en), .carrier_lost(carrier_lost),
    .data_rd(data_rd), .rx_data(rx_data), .rx_full(rx_full), .frame_err(frame_err),
    .parity_err(parity_err), .overrun(overrun), .rx_irq(rx_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) rx_tick = 1'b1;
      @(negedge clk) rx_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic host_read();
    @(negedge clk) data_rd = 1'b1;
    @(negedge clk) data_rd = 1'b0;
  endtask

  // pk: 0 none, 1 even, 2 odd
  task automatic send(input logic [7:0] d, input int nb, input int pk,
                      input bit flip, input bit stop, input int n);
    logic p;
    p = 1'b0;
    rxd = 1'b1; ticks(2);
    rxd = 1'b0; ticks(n);
    for (int i = 0; i < nb; i++) begin
      rxd = d[i]; p = p ^ d[i]; ticks(n);
    end
    if (pk != 0) begin
      rxd = ((pk == 2) ? ~p : p) ^ flip; ticks(n);
    end
    rxd = stop; ticks(n);
    rxd = 1'b1; ticks(2);
  endtask

  task automatic t_reset();
    chk("R7 reset full", rx_full, 0);
    chk("R7 reset ovr", overrun, 0);
    chk("R3 reset fe", frame_err, 0);
    chk("R9 reset irq", rx_irq, 0);
  endtask

  task automatic t_eight_bit();
    div_sel = 2'd1; word_sel = 3'd5;
    send(8'hA5, 8, 0, 0, 1, 16);
    chk("R1 full", rx_full, 1);
    chk("R1 data lsb first", rx_data, 8'hA5);
    chk("R4 no parity pe", parity_err, 0);
    host_read();
    chk("R7 read clears full", rx_full, 0);
  endtask

  task automatic t_parity();
    div_sel = 2'd1; word_sel = 3'd2;
    send(8'h53, 7, 1, 0, 1, 16);
    chk("R2 seven bit data", rx_data, 8'h53);
    chk("R4 even ok", parity_err, 0);
    host_read();
    send(8'h53, 7, 1, 1, 1, 16);
    chk("R4 even bad", parity_err, 1);
    host_read();
    word_sel = 3'd3;
    send(8'h31, 7, 2, 0, 1, 16);
    chk("R4 odd ok", parity_err, 0);
    host_read();
    word_sel = 3'd7;
    send(8'hF0, 8, 2, 1, 1, 16);
    chk("R4 odd bad 8bit", parity_err, 1);
    chk("R1 8 bit parity data", rx_data, 8'hF0);
    host_read();
    word_sel = 3'd3;
    send(8'hFF, 7, 2, 0, 1, 16);
    chk("R2 bit7 zero", rx_data[7], 0);
    chk("R2 seven ones", rx_data, 8'h7F);
    host_read();
  endtask

  task automatic t_framing();
    div_sel = 2'd1; word_sel = 3'd5;
    send(8'h3C, 8, 0, 0, 0, 16);
    chk("R3 fe set", frame_err, 1);
    chk("R3 data kept", rx_data, 8'h3C);
    host_read();
    send(8'h3D, 8, 0, 0, 1, 16);
    chk("R3 fe cleared", frame_err, 0);
    host_read();
  endtask

  task automatic t_overrun();
    div_sel = 2'd1; word_sel = 3'd6;
    send(8'h11, 8, 1, 1, 1, 16);
    send(8'h22, 8, 1, 0, 1, 16);
    chk("R6 still full", rx_full, 1);
    chk("R6 ovr hidden", overrun, 0);
    chk("R6 first char held", rx_data, 8'h11);
    chk("R5 pe held", parity_err, 1);
    host_read();
    chk("R6 ovr visible", overrun, 1);
    chk("R6 full stays", rx_full, 1);
    host_read();
    chk("R6 ovr cleared", overrun, 0);
    chk("R6 full cleared", rx_full, 0);
    send(8'h33, 8, 1, 0, 1, 16);
    chk("R12 sync kept", rx_data, 8'h33);
    chk("R12 pe clean", parity_err, 0);
    host_read();
  endtask

  task automatic t_carrier_irq();
    div_sel = 2'd1; word_sel = 3'd5; rx_irq_en = 1'b1;
    send(8'h5E, 8, 0, 0, 1, 16);
    chk("R9 irq on full", rx_irq, 1);
    @(negedge clk) carrier_lost = 1'b1;
    @(negedge clk);
    chk("R8 full masked", rx_full, 0);
    @(negedge clk) carrier_lost = 1'b0;
    @(negedge clk);
    chk("R8 full returns", rx_full, 1);
    host_read();
    chk("R9 irq clear after read", rx_irq, 0);
    @(negedge clk) carrier_lost = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R9 irq on carrier loss", rx_irq, 1);
    host_read();
    chk("R9 irq cleared by read", rx_irq, 0);
    @(negedge clk) carrier_lost = 1'b0;
    rx_irq_en = 1'b0;
    send(8'h5F, 8, 0, 0, 1, 16);
    chk("R9 irq disabled", rx_irq, 0);
    host_read();
  endtask

  task automatic t_glitch();
    div_sel = 2'd1; word_sel = 3'd5;
    rxd = 1'b0; ticks(3);
    rxd = 1'b1; ticks(20);
    chk("R10 glitch rejected", rx_full, 0);
    send(8'h5A, 8, 0, 0, 1, 16);
    chk("R10 next char intact", rx_data, 8'h5A);
    host_read();
  endtask

  task automatic t_div64();
    div_sel = 2'd2; word_sel = 3'd5;
    send(8'hC3, 8, 0, 0, 1, 64);
    chk("R10 div64 data", rx_data, 8'hC3);
    host_read();
    rxd = 1'b0; ticks(20);
    rxd = 1'b1; ticks(80);
    chk("R10 div64 glitch", rx_full, 0);
  endtask

  task automatic t_div1();
    div_sel = 2'd0; word_sel = 3'd5;
    send(8'h96, 8, 0, 0, 1, 1);
    chk("R11 div1 data", rx_data, 8'h96);
    chk("R11 div1 fe", frame_err, 0);
    host_read();
  endtask

  task automatic t_mreset();
    div_sel = 2'd1; word_sel = 3'd6;
    send(8'h44, 8, 1, 1, 0, 16);
    chk("R7 pre full", rx_full, 1);
    @(negedge clk) div_sel = 2'd3;
    @(negedge clk) div_sel = 2'd1;
    chk("R7 mr full", rx_full, 0);
    chk("R7 mr fe", frame_err, 0);
    chk("R7 mr pe", parity_err, 0);
  endtask

  initial begin
    rst_n = 1'b0; rx_tick = 1'b0; rxd = 1'b1; div_sel = 2'd1; word_sel = 3'd5;
    rx_irq_en = 1'b0; carrier_lost = 1'b0; data_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_eight_bit();
    t_parity();
    t_framing();
    t_overrun();
    t_carrier_irq();
    t_glitch();
    t_div64();
    t_div1();
    t_mreset();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule